// File: doc/BRIEF.md
# Read Strobe Polarity Detector

At the start of every read burst, this block chooses the system-clock edge that the capture path's synchronizing registers use to move read data out of the strobe domain. Before a read, the bidirectional strobe is not driven and only termination sets its level. When the memory starts to drive it, the strobe first holds low for a preamble and then rises for the first data edge. The block samples the strobe at both system-clock edges. From which of the two sample points first sees the rising strobe, it picks the polarity whose sample point lies farther from that edge. It then presents the choice as a registered polarity bit together with a one-cycle done pulse.

The controller issues a read-start pulse, and the detector arms. The detector accepts a preamble only after it has seen the strobe driven low for a parameterised number of cycles, and it takes the first high sample after that as the first strobe edge. Once a decision is made, the detector ignores the rest of the burst, including the low postamble, until the strobe returns to the undriven state. The polarity bit keeps its value until the next decision, so the capture path holds one setting for a whole burst. If no preamble arrives within a parameterised number of cycles after arming, the detector disarms and keeps its previous polarity.

Top module: `strobe_pol_det`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `clk_pol` is 0 (rising-edge capture), `pol_done` is 0, and the detector is not armed.
- R2: While not armed, a driven low preamble followed by a high strobe produces no `pol_done` pulse and leaves `clk_pol` unchanged.
- R3: After `rd_start` is accepted, MIN_PRE_CYC consecutive cycles with `strb_drv`=1, `strb_smp_r`=0 and `strb_smp_f`=0, followed by a cycle with `strb_drv`=1 and either sample high, assert `pol_done` in the next cycle.
- R4: If the first high sample after the preamble is seen on `strb_smp_f` (the falling-edge sample, taken half a period before `strb_smp_r`), whether or not `strb_smp_r` is also high, `clk_pol` becomes 0 in the same cycle as `pol_done`.
- R5: If the first high sample is seen only on `strb_smp_r` (with `strb_smp_f`=0), `clk_pol` becomes 1 (falling-edge capture) in the same cycle as `pol_done`.
- R6: `clk_pol` changes only in a cycle where `pol_done` is 1.
- R7: `pol_done` is a single-cycle pulse, and there is at most one pulse per accepted read start. A driven low postamble after the burst does not produce a second pulse.
- R8: A `rd_start` that arrives while the detector is armed, waiting for the first edge, or inside a burst is ignored. A new read start is accepted only after `strb_drv` has returned to 0.
- R9: A driven high strobe seen before the preamble has been qualified clears the preamble count, and no decision is made from it.
- R10: If no preamble is qualified within ARM_TIMEOUT cycles after arming, the detector disarms without a pulse, and strobe activity after that is ignored.
- R11: If `strb_drv` drops after the preamble is qualified but before the first high sample, the detector disarms without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | One-cycle read-start pulse from the controller |
| strb_drv | input | 1 | High while the memory drives the strobe |
| strb_smp_r | input | 1 | Strobe level sampled at this rising clock edge |
| strb_smp_f | input | 1 | Strobe level sampled at the preceding falling clock edge |
| clk_pol | output | 1 | Selected capture polarity: 0 rising edge, 1 falling edge |
| pol_done | output | 1 | One-cycle pulse when a new polarity is decided |

## Verification
The hardest situation to reach from the ports is a postamble or a second read start that arrives while a burst is still active. Reaching it takes a burst that has already been decided, with the strobe held driven through toggling data and then a low tail. The stimulus issues a full read, pulses `rd_start` in the middle of the burst, and plays a low postamble. It then presents a complete preamble and first edge without a fresh read start and expects no pulse. The timeout and the abort after qualification are reached by arming the detector and then holding the strobe undriven, or by dropping the driven flag for one cycle between the preamble and the first edge.

// File: rtl/strobe_pol_pkg.sv
package strobe_pol_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PRE   = 2'd2,
    ST_BUSY  = 2'd3
  } det_state_t;

  // The falling-edge sample precedes the rising-edge sample by half a period.
  // The sample point that first saw the strobe high sits just after the edge,
  // so the other one is farther from it.
  // Returns 1 (falling capture) only when the rising sample alone saw it.
  function automatic logic pick_pol(input logic smp_r, input logic smp_f);
    return smp_r & ~smp_f;
  endfunction

  function automatic logic strobe_low(input logic drv, input logic smp_r,
                                      input logic smp_f);
    return drv & ~smp_r & ~smp_f;
  endfunction

  function automatic logic strobe_high(input logic drv, input logic smp_r,
                                       input logic smp_f);
    return drv & (smp_r | smp_f);
  endfunction

endpackage

// File: rtl/strobe_pre_qual.sv
module strobe_pre_qual
  import strobe_pol_pkg::*;
#(
  parameter int MIN_PRE_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drv,
  input  logic smp_r,
  input  logic smp_f,
  output logic qual_o
);
  localparam int CW = (MIN_PRE_CYC < 2) ? 1 : $clog2(MIN_PRE_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_PRE_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          low_now;

  assign low_now = strobe_low(drv, smp_r, smp_f);
  assign qual_o  = en & low_now & (low_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!en || !low_now) begin
      low_cnt <= '0;
    end else if (low_cnt != LAST) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/strobe_arm_timer.sv
module strobe_arm_timer #(
  parameter int ARM_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire_o
);
  localparam int TW = (ARM_TIMEOUT < 2) ? 1 : $clog2(ARM_TIMEOUT);
  localparam logic [TW-1:0] LAST = TW'(ARM_TIMEOUT - 1);

  logic [TW-1:0] wait_cnt;

  assign expire_o = en & (wait_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      wait_cnt <= '0;
    end else if (wait_cnt != LAST) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/strobe_edge_pick.sv
module strobe_edge_pick
  import strobe_pol_pkg::*;
(
  input  logic drv,
  input  logic smp_r,
  input  logic smp_f,
  output logic seen_o,
  output logic pol_o
);
  assign seen_o = strobe_high(drv, smp_r, smp_f);
  assign pol_o  = pick_pol(smp_r, smp_f);
endmodule

// File: rtl/strobe_pol_det.sv
module strobe_pol_det
  import strobe_pol_pkg::*;
#(
  parameter int MIN_PRE_CYC = 1,
  parameter int ARM_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic strb_drv,
  input  logic strb_smp_r,
  input  logic strb_smp_f,
  output logic clk_pol,
  output logic pol_done
);

  det_state_t state, state_nx;

  logic st_idle, st_armed, st_pre, st_busy;
  logic evt_arm, evt_qual, evt_tmo, evt_decide, evt_abort, evt_release;
  logic qual_w, tmo_w, seen_w, pol_w;

  assign st_idle  = (state == ST_IDLE);
  assign st_armed = (state == ST_ARMED);
  assign st_pre   = (state == ST_PRE);
  assign st_busy  = (state == ST_BUSY);

  strobe_pre_qual #(.MIN_PRE_CYC(MIN_PRE_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(st_armed),
    .drv(strb_drv), .smp_r(strb_smp_r), .smp_f(strb_smp_f),
    .qual_o(qual_w)
  );

  strobe_arm_timer #(.ARM_TIMEOUT(ARM_TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(st_armed), .expire_o(tmo_w)
  );

  strobe_edge_pick u_pick (
    .drv(strb_drv), .smp_r(strb_smp_r), .smp_f(strb_smp_f),
    .seen_o(seen_w), .pol_o(pol_w)
  );

  // Named events for the checker
  assign evt_arm     = st_idle & rd_start;
  assign evt_qual    = qual_w;
  assign evt_tmo     = tmo_w & ~qual_w;
  assign evt_decide  = st_pre & seen_w;
  assign evt_abort   = st_pre & ~strb_drv;
  assign evt_release = st_busy & ~strb_drv;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (evt_arm)     state_nx = ST_ARMED;
      ST_ARMED: if (evt_qual)    state_nx = ST_PRE;
                else if (evt_tmo) state_nx = ST_IDLE;
      ST_PRE:   if (evt_decide)  state_nx = ST_BUSY;
                else if (evt_abort) state_nx = ST_IDLE;
      ST_BUSY:  if (evt_release) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      clk_pol  <= 1'b0;
      pol_done <= 1'b0;
    end else begin
      state    <= state_nx;
      pol_done <= evt_decide;
      if (evt_decide) clk_pol <= pol_w;
    end
  end

endmodule

// File: rtl/strobe_pol_det_chk.sv
module strobe_pol_det_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_start,
  input logic strb_drv,
  input logic strb_smp_r,
  input logic strb_smp_f,
  input logic clk_pol,
  input logic pol_done,
  input logic st_armed,
  input logic st_pre,
  input logic st_busy
);

  // R3
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_done |-> $past(strb_drv) && ($past(strb_smp_r) || $past(strb_smp_f)));

  // R4
  pol_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_done |-> (clk_pol == ($past(strb_smp_r) && !$past(strb_smp_f))));

  // R6
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_pol) |-> pol_done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_done |=> !pol_done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && rd_start && strb_drv) |=> !st_armed);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pre && !strb_drv) |=> !pol_done && !st_pre);

endmodule

bind strobe_pol_det strobe_pol_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .strb_drv(strb_drv),
  .strb_smp_r(strb_smp_r), .strb_smp_f(strb_smp_f), .clk_pol(clk_pol),
  .pol_done(pol_done), .st_armed(st_armed), .st_pre(st_pre), .st_busy(st_busy)
);

// File: tb/strobe_pol_det_test.sv
module strobe_pol_det_test;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n, rd_start, strb_drv, strb_smp_r, strb_smp_f;
  logic clk_pol, pol_done;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  strobe_pol_det #(.MIN_PRE_CYC(1), .ARM_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .strb_drv(strb_drv),
    .strb_smp_r(strb_smp_r), .strb_smp_f(strb_smp_f),
    .clk_pol(clk_pol), .pol_done(pol_done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic r, input logic f);
    strb_drv = d; strb_smp_r = r; strb_smp_f = f;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic start_read();
    rd_start = 1'b1; cyc(); rd_start = 1'b0;
  endtask

  // drive a pattern for n cycles, checking no pulse and steady polarity
  task automatic quiet(input string req, input int n, input logic d,
                       input logic r, input logic f, input logic pol_exp);
    drive(d, r, f);
    for (int i = 0; i < n; i++) begin
      cyc();
      chk(req, pol_done, 1'b0);
      chk(req, clk_pol, pol_exp);
    end
  endtask

  // release strobe and let the detector settle back
  task automatic release_strobe();
    drive(1'b0, 1'b1, 1'b1); cyc(); cyc();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rd_start = 1'b0; drive(1'b0, 1'b1, 1'b1);
    repeat (3) cyc();
    chk("R1 pol", clk_pol, 1'b0);
    chk("R1 done", pol_done, 1'b0);
    rst_n = 1'b1; cyc();
    chk("R1 pol after", clk_pol, 1'b0);
    chk("R1 done after", pol_done, 1'b0);
  endtask

  task automatic t_idle_ignore(input logic pol_now);
    quiet("R2 preamble", 2, 1'b1, 1'b0, 1'b0, pol_now);
    quiet("R2 edge", 3, 1'b1, 1'b1, 1'b0, pol_now);
    release_strobe();
  endtask

  // full read: preamble, first edge (r,f), burst, postamble, release
  task automatic t_read(input string req, input logic r, input logic f,
                        input logic exp_pol, input logic prev_pol);
    start_read();
    drive(1'b1, 1'b0, 1'b0); cyc();
    chk({req, " R3 no early done"}, pol_done, 1'b0);
    chk({req, " R6 pol held"}, clk_pol, prev_pol);
    drive(1'b1, r, f); cyc();
    chk({req, " R3 done"}, pol_done, 1'b1);
    chk({req, " pol"}, clk_pol, exp_pol);
    drive(1'b1, 1'b0, 1'b1); cyc();
    chk({req, " R7 pulse width"}, pol_done, 1'b0);
    quiet({req, " R6 burst"}, 3, 1'b1, 1'b1, 1'b0, exp_pol);
    quiet({req, " R7 postamble"}, 3, 1'b1, 1'b0, 1'b0, exp_pol);
    quiet({req, " R7 after postamble"}, 2, 1'b1, 1'b0, 1'b1, exp_pol);
    release_strobe();
  endtask

  task automatic t_busy_start();
    start_read();
    drive(1'b1, 1'b0, 1'b0); cyc();
    drive(1'b1, 1'b1, 1'b0); cyc();
    chk("R8 first done", pol_done, 1'b1);
    chk("R8 pol", clk_pol, 1'b1);
    rd_start = 1'b1; drive(1'b1, 1'b0, 1'b1); cyc(); rd_start = 1'b0;
    quiet("R8 postamble", 3, 1'b1, 1'b0, 1'b0, 1'b1);
    quiet("R8 re-edge", 3, 1'b1, 1'b0, 1'b1, 1'b1);
    release_strobe();
    quiet("R8 preamble no start", 2, 1'b1, 1'b0, 1'b0, 1'b1);
    quiet("R8 edge no start", 2, 1'b1, 1'b1, 1'b1, 1'b1);
    release_strobe();
    t_read("R8 fresh start R4", 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_glitch();
    start_read();
    quiet("R9 driven high before preamble", 2, 1'b1, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0); cyc();
    chk("R9 preamble", pol_done, 1'b0);
    drive(1'b1, 1'b1, 1'b0); cyc();
    chk("R9 done after real preamble", pol_done, 1'b1);
    chk("R9 R5 pol", clk_pol, 1'b1);
    release_strobe();
  endtask

  task automatic t_timeout();
    start_read();
    quiet("R10 waiting", TMO + 2, 1'b0, 1'b1, 1'b1, 1'b1);
    quiet("R10 late preamble", 2, 1'b1, 1'b0, 1'b0, 1'b1);
    quiet("R10 late edge", 3, 1'b1, 1'b0, 1'b1, 1'b1);
    release_strobe();
  endtask

  task automatic t_abort();
    start_read();
    drive(1'b1, 1'b0, 1'b0); cyc();
    quiet("R11 drop", 1, 1'b0, 1'b0, 1'b0, 1'b1);
    quiet("R11 edge after drop", 3, 1'b1, 1'b0, 1'b1, 1'b1);
    release_strobe();
  endtask

  initial begin
    t_reset();
    t_idle_ignore(1'b0);
    t_read("R5 rising-only", 1'b1, 1'b0, 1'b1, 1'b0);
    t_read("R4 falling-only", 1'b0, 1'b1, 1'b0, 1'b1);
    t_read("R5 again", 1'b1, 1'b0, 1'b1, 1'b0);
    t_read("R4 both high", 1'b1, 1'b1, 1'b0, 1'b1);
    t_busy_start();
    t_glitch();
    t_timeout();
    t_abort();
    t_idle_ignore(1'b1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule